// File: doc/BRIEF.md
# Address-Space TLB Sweep Engine

This engine removes one process's translations from the translation caches. A one-cycle start pulse carries a requested address-space ID. The engine then reads every entry of the instruction and data TLB arrays through a synchronous read port. For each entry owned by that ID, it sends an invalidate-page request downstream. The engine does not clear entries itself and does not perform lookups. A separate page-invalidation agent consumes its requests over a valid/ready handshake.

Entries that are marked global are never selected, and neither are entries that are not valid. The walk visits the arrays one after another, the ways within each array, and the indices within each way. Requests therefore leave in that order. The read port has a latency of one cycle. The engine overlaps the issue of the next read address with the check of the entry that has just returned. When the downstream side applies backpressure, the engine stops issuing reads until the request is taken.

Top module: `tlb_asid_sweep`

## Requirements
- R1: After reset, busy, done, rdEn and invValid are all 0.
- R2: Only the low 8 bits of reqPid are used as the ID. Upper bits never affect which entries are selected.
- R3: One walk issues exactly 128 reads, one per entry, in this order: array, then way, then index. The entry number n (0..127) is split as rdArray = n[6], rdWay = n[5:4], rdIndex = n[3:0]. No read is issued while busy is low.
- R4: An entry is selected when all three of these hold: lo bit 3 (valid) is 1, lo bit 4 (global) is 0, and hi bits [7:0] equal the latched ID. All other bits of lo are ignored.
- R5: The request address is hi[31:13] followed by thirteen zero bits. Bits [12:8] of hi never appear in it.
- R6: Each selected entry produces exactly one accepted request, in walk order. Unselected entries produce none.
- R7: While invValid is 1 and invReady is 0, invValid and invAddr hold their values and rdEn stays 0.
- R8: busy rises in the cycle after an accepted start and falls together with a one-cycle done pulse. That pulse comes only after the last request has been accepted.
- R9: A start pulse that arrives while busy is ignored. It changes neither the ID in use nor the number of walks or done pulses.
- R10: Read data is taken from rdHi/rdLo exactly one cycle after the rdEn that requested it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | One-cycle request to begin a walk |
| reqPid | input | 16 | Requested ID; only bits [7:0] are used |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when a walk ends |
| rdEn | output | 1 | Entry read strobe |
| rdArray | output | 1 | Array select (0 instruction, 1 data) |
| rdWay | output | 2 | Way select |
| rdIndex | output | 4 | Index select |
| rdHi | input | 32 | Entry tag word, valid one cycle after rdEn |
| rdLo | input | 32 | Entry attribute word, valid one cycle after rdEn |
| invValid | output | 1 | Invalidate request present |
| invReady | input | 1 | Downstream accepts the request |
| invAddr | output | 32 | Page address to invalidate |

## Verification
The embedded assertions check the following on every cycle:
- the handshake hold rule and the stall of read issue under backpressure,
- the zero page offset of every request address,
- that no returning hit can overwrite a pending request,
- that busy and done fall and rise together.

Only the bench scenarios can show the rest: which entries are selected, the exact read order, the masking of the ID, the one-cycle read alignment, and that a start during a walk is ignored. The bench checks these against an entry table it keeps itself, under several patterns of ready activity.

// File: rtl/tlbsweep_pkg.sv
package tlbsweep_pkg;
  localparam int ASID_W     = 8;
  localparam int VALID_BIT  = 3;
  localparam int GLOBAL_BIT = 4;
  localparam int VPN_LSB    = 13;

  typedef struct packed {
    logic loadPid;
    logic issueRd;
  } sweepCtl_t;

  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_WALK  = 2'd1,
    SW_DRAIN = 2'd2
  } sweepState_e;
endpackage

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import tlbsweep_pkg::*;
#(
  parameter int ENT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startReq,
  input  logic             hitNow,
  input  logic             outStall,
  input  logic             pipeEmpty,
  output sweepCtl_t        ctl,
  output logic [ENT_W-1:0] entryIdx,
  output logic             busy,
  output logic             done
);
  localparam logic [ENT_W-1:0] LAST_ENT = {ENT_W{1'b1}};

  sweepState_e state;

  always_comb begin
    ctl         = '0;
    ctl.loadPid = (state == SW_IDLE) && startReq;
    // a hit returning this cycle fills the output slot, so hold issue one cycle
    ctl.issueRd = (state == SW_WALK) && !outStall && !hitNow;
  end

  assign busy = (state != SW_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SW_IDLE;
      entryIdx <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SW_IDLE: begin
          if (startReq) begin
            state    <= SW_WALK;
            entryIdx <= '0;
          end
        end
        SW_WALK: begin
          if (ctl.issueRd) begin
            entryIdx <= entryIdx + 1'b1;
            if (entryIdx == LAST_ENT) state <= SW_DRAIN;
          end
        end
        SW_DRAIN: begin
          if (pipeEmpty) begin
            state <= SW_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= SW_IDLE;
      endcase
    end
  end

  // R8: done coincides with the fall of busy
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R3: reads only during a walk
  a_r3_issue_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.issueRd |-> busy);
  // R7: no read while the request output is stalled
  a_r7_stall_blocks_issue: assert property (@(posedge clk) disable iff (!rst_n)
    outStall |-> !ctl.issueRd);
endmodule

// File: rtl/sweep_datapath.sv
module sweep_datapath
  import tlbsweep_pkg::*;
#(
  parameter int REQ_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sweepCtl_t         ctl,
  input  logic [REQ_W-1:0]  reqPid,
  input  logic [DATA_W-1:0] rdHi,
  input  logic [DATA_W-1:0] rdLo,
  input  logic              invReady,
  output logic              invValid,
  output logic [DATA_W-1:0] invAddr,
  output logic              hitNow,
  output logic              outStall,
  output logic              pipeEmpty
);
  logic [ASID_W-1:0] pidReg;
  logic              dataVld;
  logic              entryQual;
  logic              unusedBits;

  assign unusedBits = ^{reqPid[REQ_W-1:ASID_W], rdHi[VPN_LSB-1:ASID_W],
                        rdLo[DATA_W-1:GLOBAL_BIT+1], rdLo[VALID_BIT-1:0]};

  assign entryQual = rdLo[VALID_BIT] && !rdLo[GLOBAL_BIT]
                     && (rdHi[ASID_W-1:0] == pidReg);
  assign hitNow    = dataVld && entryQual;
  assign outStall  = invValid && !invReady;
  assign pipeEmpty = !dataVld && !invValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pidReg   <= '0;
      dataVld  <= 1'b0;
      invValid <= 1'b0;
      invAddr  <= '0;
    end else begin
      if (ctl.loadPid) pidReg <= reqPid[ASID_W-1:0];
      dataVld <= ctl.issueRd;
      if (hitNow) begin
        invValid <= 1'b1;
        invAddr  <= {rdHi[DATA_W-1:VPN_LSB], {VPN_LSB{1'b0}}};
      end else if (invReady) begin
        invValid <= 1'b0;
      end
    end
  end

  // R7: request holds under backpressure
  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (invValid && !invReady) |=> (invValid && $stable(invAddr)));
  // R5: page offset bits are zero
  a_r5_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    invValid |-> (invAddr[VPN_LSB-1:0] == '0));
  // R6: a returning hit never overwrites a pending request
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    hitNow |-> (!invValid || invReady));
endmodule

// File: rtl/tlb_asid_sweep.sv
module tlb_asid_sweep
  import tlbsweep_pkg::*;
#(
  parameter int ARR_W  = 1,
  parameter int WAY_W  = 2,
  parameter int IDX_W  = 4,
  parameter int REQ_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic [REQ_W-1:0]  reqPid,
  output logic              busy,
  output logic              done,
  output logic              rdEn,
  output logic [ARR_W-1:0]  rdArray,
  output logic [WAY_W-1:0]  rdWay,
  output logic [IDX_W-1:0]  rdIndex,
  input  logic [DATA_W-1:0] rdHi,
  input  logic [DATA_W-1:0] rdLo,
  output logic              invValid,
  input  logic              invReady,
  output logic [DATA_W-1:0] invAddr
);
  localparam int ENT_W = ARR_W + WAY_W + IDX_W;

  sweepCtl_t        ctl;
  logic [ENT_W-1:0] entryIdx;
  logic             hitNow;
  logic             outStall;
  logic             pipeEmpty;

  sweep_ctrl #(.ENT_W(ENT_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .hitNow(hitNow),
    .outStall(outStall), .pipeEmpty(pipeEmpty), .ctl(ctl),
    .entryIdx(entryIdx), .busy(busy), .done(done)
  );

  sweep_datapath #(.REQ_W(REQ_W), .DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .reqPid(reqPid), .rdHi(rdHi),
    .rdLo(rdLo), .invReady(invReady), .invValid(invValid), .invAddr(invAddr),
    .hitNow(hitNow), .outStall(outStall), .pipeEmpty(pipeEmpty)
  );

  assign rdEn = ctl.issueRd;
  assign {rdArray, rdWay, rdIndex} = entryIdx;
endmodule

// File: tb/test_tlb_asid_sweep.sv
`timescale 1ns/1ps
module test_tlb_asid_sweep;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startReq = 1'b0;
  logic [15:0] reqPid = '0;
  logic        busy, done, rdEn, invValid;
  logic        invReady = 1'b0;
  logic [0:0]  rdArray;
  logic [1:0]  rdWay;
  logic [3:0]  rdIndex;
  logic [31:0] rdHi = '0, rdLo = '0, invAddr;

  int testCount = 0, failCount = 0;
  int readyPct = 100;
  logic [31:0] memHi [128];
  logic [31:0] memLo [128];
  logic [31:0] expAddr [128];
  int expCnt, accCount, rdExpect, doneCount;
  logic prevStall = 1'b0, prevDone = 1'b0;
  logic [31:0] prevAddr = '0;

  always #10 clk = ~clk;

  tlb_asid_sweep i_tlb_asid_sweep (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .reqPid(reqPid),
    .busy(busy), .done(done), .rdEn(rdEn), .rdArray(rdArray), .rdWay(rdWay),
    .rdIndex(rdIndex), .rdHi(rdHi), .rdLo(rdLo), .invValid(invValid),
    .invReady(invReady), .invAddr(invAddr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit selects(input logic [31:0] hi, input logic [31:0] lo,
                                 input logic [15:0] pid);
    return lo[3] && !lo[4] && (hi[7:0] == pid[7:0]);
  endfunction

  // read port model: data one cycle after rdEn, garbage otherwise (R10)
  always @(posedge clk) begin
    if (rdEn) begin
      rdHi <= memHi[{rdArray, rdWay, rdIndex}];
      rdLo <= memLo[{rdArray, rdWay, rdIndex}];
    end else begin
      rdHi <= $urandom;
      rdLo <= $urandom;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1 invReady = ($urandom % 100) < readyPct;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (prevStall)
      chk(invValid && invAddr == prevAddr, "R7 hold", invAddr, prevAddr);
    if (invValid && !invReady)
      chk(!rdEn, "R7 stall", {31'b0, rdEn}, 32'd0);
    prevStall = invValid && !invReady;
    prevAddr  = invAddr;
    if (rdEn) begin
      chk(busy && {rdArray, rdWay, rdIndex} == rdExpect[6:0], "R3 order",
          {25'b0, rdArray, rdWay, rdIndex}, rdExpect);
      rdExpect++;
    end
    if (invValid && invReady) begin
      if (accCount < expCnt)
        chk(invAddr == expAddr[accCount], "R4 R5 R6 R10 address",
            invAddr, expAddr[accCount]);
      else
        chk(1'b0, "R6 extra request", invAddr, 32'd0);
      accCount++;
    end
    if (done) begin
      doneCount++;
      chk(!prevDone, "R8 done pulse", 32'd1, 32'd0);
    end
    prevDone = done;
  end

  task automatic runWalk(input logic [15:0] pid, input int pct, input int injectAt);
    int n = 0;
    int startDone = doneCount;
    expCnt = 0;
    for (int e = 0; e < 128; e++)
      if (selects(memHi[e], memLo[e], pid))
        expAddr[expCnt++] = {memHi[e][31:13], 13'b0};
    accCount = 0;
    rdExpect = 0;
    readyPct = pct;
    @(posedge clk); #2;
    startReq = 1'b1; reqPid = pid;
    @(posedge clk); #2;
    startReq = 1'b0;
    @(negedge clk); #1;
    chk(busy, "R8 busy after start", {31'b0, busy}, 32'd1);
    while (doneCount == startDone && n < 5000) begin
      @(negedge clk); #1;
      n++;
      if (n == injectAt) begin startReq = 1'b1; reqPid = pid ^ 16'h00FF; end
      else if (n == injectAt + 1) startReq = 1'b0;
    end
    chk(n < 5000, "R8 walk finishes", n, 5000);
    chk(accCount == expCnt, "R6 request count", accCount, expCnt);
    chk(rdExpect == 128, "R3 read count", rdExpect, 128);
    chk(!busy, "R8 busy low at done", {31'b0, busy}, 32'd0);
    repeat (6) @(negedge clk);
    #1;
    chk(doneCount == startDone + 1, "R9 single walk", doneCount, startDone + 1);
    chk(rdExpect == 128 && !busy, "R9 no restart", rdExpect, 128);
  endtask

  initial begin
    #4000000;
    failCount++;
    testCount++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [7:0] pool [4];
    void'($urandom(32'd4242));
    expCnt = 0; accCount = 0; rdExpect = 0; doneCount = 0;
    for (int e = 0; e < 128; e++) begin memHi[e] = '0; memLo[e] = '0; end
    repeat (3) @(posedge clk);
    #2;
    chk(!busy && !done && !rdEn && !invValid, "R1 reset state",
        {28'b0, busy, done, rdEn, invValid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !rdEn && !invValid, "R1 idle after reset",
        {29'b0, busy, rdEn, invValid}, 32'd0);

    // directed table: ID A5, request carries junk upper bits (R2)
    memHi[0]   = {19'h00001, 5'h00, 8'hA5}; memLo[0]   = 32'h0000_0008;
    memHi[1]   = {19'h00002, 5'h00, 8'hA5}; memLo[1]   = 32'h0000_0018;
    memHi[2]   = {19'h00003, 5'h00, 8'hA5}; memLo[2]   = 32'hFFFF_FFE7;
    memHi[3]   = {19'h00004, 5'h00, 8'hA4}; memLo[3]   = 32'h0000_0008;
    memHi[4]   = {19'h00005, 5'h1F, 8'hA5}; memLo[4]   = 32'hFFFF_FFEF;
    memHi[5]   = {19'h00006, 5'h00, 8'hA5}; memLo[5]   = 32'h0000_000F;
    memHi[64]  = {19'h40000, 5'h00, 8'hA5}; memLo[64]  = 32'h0000_0008;
    memHi[127] = {19'h7FFFF, 5'h1F, 8'hA5}; memLo[127] = 32'h0000_000F;
    runWalk(16'h1AA5, 100, 0);
    chk(expCnt == 5, "R4 directed selection count", expCnt, 5);
    runWalk(16'h1AA5, 30, 0);

    // random tables with a small ID pool
    pool[0] = 8'hA5; pool[1] = 8'h3C; pool[2] = 8'h00; pool[3] = 8'hFF;
    for (int r = 0; r < 5; r++) begin
      for (int e = 0; e < 128; e++) begin
        memHi[e] = {$urandom} & 32'hFFFF_FF00 | {24'b0, pool[$urandom % 4]};
        memLo[e] = $urandom;
      end
      runWalk({8'($urandom), pool[r % 4]}, (r == 0) ? 100 : 20 + 20 * r,
              (r == 3) ? 25 : 0);
    end
    // start during a walk must be ignored (R9)
    runWalk(16'h003C, 60, 40);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule